// File: doc/BRIEF.md
# Gated Non-Retriggerable One-Shot

This block is a clocked pulse generator that replaces a resistor-capacitor monostable with a cycle counter. It watches two asynchronous trigger lines. The first line fires on a falling edge, and only while the second line is high. The second line fires on a rising edge, and only while the first line is low. Each line therefore serves either as a trigger or as a gate for the other. When the block fires, it latches an unsigned width value. It then holds its true output high for exactly that many clock cycles, and its inverted output is the exact complement.

Once a pulse is running, the block ignores both trigger lines and the width input until the pulse has finished. A synchronous active-low clear overrides everything. It drops the pulse on the next clock edge, it masks triggers for as long as it is held, and releasing it never starts a pulse. A dual-channel part is built from two instances of this block.

Top module: `gated_one_shot`

## Requirements
- R1: A falling edge on `fallTrigIn` while `riseTrigIn` is high starts a pulse. `pulseOut` is first seen high 3 rising clock edges after the input change: two synchroniser stages plus the output register.
- R2: A rising edge on `riseTrigIn` while `fallTrigIn` is low starts a pulse, with the same 3-edge latency.
- R3: A falling edge on `fallTrigIn` while `riseTrigIn` is low starts no pulse. A rising edge on `riseTrigIn` while `fallTrigIn` is high starts no pulse.
- R4: `pulseOut` stays high for exactly N clock cycles, where N is the unsigned value of `widthIn` sampled in the firing cycle. A value of 0 gives a pulse of 1 cycle.
- R5: While a pulse is active, further edges on either trigger line and changes of `widthIn` do not restart, extend or shorten it.
- R6: When `clrN` is sampled low, `pulseOut` is low after that clock edge. Trigger edges seen while `clrN` is low start nothing, and releasing `clrN` starts no pulse.
- R7: A trigger edge detected in the final high cycle of a pulse is dropped. An edge detected one cycle later starts a new pulse after one low cycle.
- R8: After reset, `pulseOut` is 0 and `pulseOutN` is 1. `pulseOutN` is the complement of `pulseOut` in every cycle.
- R9: The pulse length does not depend on how long a trigger line stays at its new level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clrN | input | 1 | Synchronous active-low clear, overrides triggers |
| fallTrigIn | input | 1 | Asynchronous trigger, fires on a falling edge, gates the other line |
| riseTrigIn | input | 1 | Asynchronous trigger, fires on a rising edge, gates the other line |
| widthIn | input | WIDTH_BITS | Pulse length in cycles, latched at firing |
| pulseOut | output | 1 | Registered pulse output |
| pulseOutN | output | 1 | Registered complement of pulseOut |

## Verification
A pulse is due on the third rising edge after a trigger input changes. It lasts as many edges as the latched width, and a clear takes effect on the first edge that samples it. The driver records the cycle in which it changes an input and pushes the expected start cycle and length into a queue. A monitor samples one nanosecond after each rising edge, measures every high run of `pulseOut` and compares it with the head of the queue. A run that appears when the queue is empty counts as a failure, and that is how the inhibited, masked and dropped edges are checked.

// File: rtl/gated_one_shot_pkg.sv
package gated_one_shot_pkg;

  // Strobes issued by the control unit to the counting datapath.
  typedef struct packed {
    logic load;       // latch the width and start counting
    logic decrement;  // one cycle of the pulse has elapsed
    logic halt;       // abandon the count (clear or end)
  } pulseCmd_t;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_PULSE = 1'b1
  } pulseState_t;

endpackage

// File: rtl/gated_one_shot_sync.sv
module gated_one_shot_sync #(
  parameter int STAGES = 2,
  parameter int LANES  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LANES-1:0] asyncIn,
  output logic [LANES-1:0] syncOut
);

  localparam int LAST = STAGES - 1;

  for (genvar lane = 0; lane < LANES; lane++) begin : gLane
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chain <= '0;
      end else if (STAGES == 1) begin
        chain <= asyncIn[lane];
      end else begin
        chain <= {chain[STAGES-2:0], asyncIn[lane]};
      end
    end

    assign syncOut[lane] = chain[LAST];
  end

endmodule

// File: rtl/gated_one_shot_datapath.sv
module gated_one_shot_datapath
  import gated_one_shot_pkg::*;
#(
  parameter int WIDTH_BITS = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  pulseCmd_t             cmd,
  input  logic [WIDTH_BITS-1:0] widthIn,
  output logic                  lastCycle
);

  localparam logic [WIDTH_BITS-1:0] ONE = {{(WIDTH_BITS-1){1'b0}}, 1'b1};

  logic [WIDTH_BITS-1:0] remaining;
  logic [WIDTH_BITS-1:0] loadValue;

  // A zero width is promoted to the shortest legal pulse.
  always_comb begin
    loadValue = (widthIn == '0) ? ONE : widthIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remaining <= '0;
    end else if (cmd.halt) begin
      remaining <= '0;
    end else if (cmd.load) begin
      remaining <= loadValue;
    end else if (cmd.decrement && remaining != '0) begin
      remaining <= remaining - ONE;
    end
  end

  assign lastCycle = (remaining == ONE);

  AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    cmd.load && !cmd.halt |=> remaining != '0); // R4

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    cmd.decrement && !cmd.halt && !cmd.load && remaining > ONE
      |=> remaining == $past(remaining) - ONE); // R4

endmodule

// File: rtl/gated_one_shot_ctrl.sv
module gated_one_shot_ctrl
  import gated_one_shot_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      clrN,
  input  logic      fallSync,
  input  logic      riseSync,
  input  logic      lastCycle,
  output pulseCmd_t cmd,
  output logic      qOut,
  output logic      qOutN
);

  // Edges are masked until the synchronisers and the history flops hold real samples.
  localparam int WARM_CYCLES = SYNC_STAGES + 1;
  localparam int WARM_BITS   = $clog2(WARM_CYCLES + 1);
  localparam logic [WARM_BITS-1:0] WARM_LIMIT = WARM_BITS'(WARM_CYCLES);

  logic [WARM_BITS-1:0] warmCnt;
  logic armed;
  logic fallPrev, risePrev;
  logic fallEdge, riseEdge;
  logic fireReq;
  pulseState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      warmCnt <= '0;
    end else if (warmCnt != WARM_LIMIT) begin
      warmCnt <= warmCnt + 1'b1;
    end
  end

  assign armed = (warmCnt == WARM_LIMIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fallPrev <= 1'b0;
      risePrev <= 1'b0;
    end else begin
      fallPrev <= fallSync;
      risePrev <= riseSync;
    end
  end

  // Each line is gated by the present level of the other.
  always_comb begin
    fallEdge = armed && fallPrev && !fallSync;
    riseEdge = armed && !risePrev && riseSync;
    fireReq  = (fallEdge && riseSync) || (riseEdge && !fallSync);
  end

  always_comb begin
    stateNext = state;
    cmd       = '0;
    if (!clrN) begin
      stateNext = ST_IDLE;
      cmd.halt  = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (fireReq) begin
            stateNext = ST_PULSE;
            cmd.load  = 1'b1;
          end
        end
        ST_PULSE: begin
          if (lastCycle) begin
            stateNext = ST_IDLE;
            cmd.halt  = 1'b1;
          end else begin
            cmd.decrement = 1'b1;
          end
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      qOut  <= 1'b0;
      qOutN <= 1'b1;
    end else begin
      state <= stateNext;
      qOut  <= (stateNext == ST_PULSE);
      qOutN <= (stateNext != ST_PULSE);
    end
  end

  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    !clrN |=> !qOut); // R6

  AST_NO_EARLY_END: assert property (@(posedge clk) disable iff (!rstN)
    qOut && !lastCycle && clrN |=> qOut); // R5

  AST_END_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    qOut && lastCycle |=> !qOut); // R7

  AST_INHIBITED_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !qOut && !(fallPrev && !fallSync && riseSync)
      && !(!risePrev && riseSync && !fallSync) |=> !qOut); // R3

  AST_OUT_COMPLEMENT: assert property (@(posedge clk) disable iff (!rstN)
    qOutN == !qOut); // R8

endmodule

// File: rtl/gated_one_shot.sv
module gated_one_shot
  import gated_one_shot_pkg::*;
#(
  parameter int WIDTH_BITS  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  clrN,
  input  logic                  fallTrigIn,
  input  logic                  riseTrigIn,
  input  logic [WIDTH_BITS-1:0] widthIn,
  output logic                  pulseOut,
  output logic                  pulseOutN
);

  localparam int TRIG_LANES = 2;

  logic [TRIG_LANES-1:0] trigSync;
  pulseCmd_t cmd;
  logic lastCycle;

  gated_one_shot_sync #(
    .STAGES(SYNC_STAGES),
    .LANES (TRIG_LANES)
  ) sync_i (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn({riseTrigIn, fallTrigIn}),
    .syncOut(trigSync)
  );

  gated_one_shot_ctrl #(
    .SYNC_STAGES(SYNC_STAGES)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .clrN     (clrN),
    .fallSync (trigSync[0]),
    .riseSync (trigSync[1]),
    .lastCycle(lastCycle),
    .cmd      (cmd),
    .qOut     (pulseOut),
    .qOutN    (pulseOutN)
  );

  gated_one_shot_datapath #(
    .WIDTH_BITS(WIDTH_BITS)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .widthIn  (widthIn),
    .lastCycle(lastCycle)
  );

endmodule

// File: tb/gated_one_shot_tb_top.sv
module gated_one_shot_tb_top;

  localparam int WB = 16;

  typedef struct {
    int    startCyc;
    int    len;
    string tag;
  } expPulse_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clrN = 1'b1;
  logic fallTrig = 1'b0;
  logic riseTrig = 1'b0;
  logic [WB-1:0] width = '0;
  logic q, qN;

  int cyc = 0;
  int nChecks = 0;
  int nFails = 0;
  int complementErrs = 0;
  bit done = 1'b0;
  bit inPulse = 1'b0;
  int runStart = 0;
  int runLen = 0;
  expPulse_t expQ[$];

  gated_one_shot #(.WIDTH_BITS(WB), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rstN(rstN), .clrN(clrN),
    .fallTrigIn(fallTrig), .riseTrigIn(riseTrig),
    .widthIn(width), .pulseOut(q), .pulseOutN(qN)
  );

  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectPulse(input int startCyc, input int len, input string tag);
    expPulse_t item;
    item.startCyc = startCyc;
    item.len = len;
    item.tag = tag;
    expQ.push_back(item);
  endtask

  // Monitor: measures each high run of q and compares it with the queue head.
  always @(posedge clk) begin
    #1;
    if (rstN) begin
      if (qN !== ~q) complementErrs++;
      if (q && !inPulse) begin
        inPulse = 1'b1;
        runStart = cyc;
        runLen = 1;
      end else if (q && inPulse) begin
        runLen++;
      end else if (!q && inPulse) begin
        inPulse = 1'b0;
        if (expQ.size() == 0) begin
          check(1'b0, "R3/R5/R6/R7 unexpected pulse start", runStart, -1);
        end else begin
          expPulse_t e;
          e = expQ.pop_front();
          check(runStart == e.startCyc, {e.tag, " start cycle"}, runStart, e.startCyc);
          check(runLen == e.len, {e.tag, " length"}, runLen, e.len);
        end
      end
    end
  end

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  initial begin
    int d;
    ticks(3);
    check(q == 1'b0, "R8 reset pulseOut", q, 0);
    check(qN == 1'b1, "R8 reset pulseOutN", qN, 1);
    rstN = 1'b1;
    ticks(8);

    // r3_ B rising while A high: inhibited
    fallTrig = 1'b1;
    ticks(4);
    riseTrig = 1'b1;
    ticks(8);
    check(q == 1'b0, "R3 rise inhibited by high A", q, 0);

    // R1: A falls with B high
    width = 16'd5;
    d = cyc; fallTrig = 1'b0;
    expectPulse(d + 3, 5, "R1");
    ticks(12);

    // R2: B rises with A low
    riseTrig = 1'b0;
    ticks(4);
    width = 16'd7;
    d = cyc; riseTrig = 1'b1;
    expectPulse(d + 3, 7, "R2");
    ticks(14);

    // R3: A falls with B low
    riseTrig = 1'b0;
    fallTrig = 1'b1;
    ticks(4);
    fallTrig = 1'b0;
    ticks(8);
    check(q == 1'b0, "R3 fall inhibited by low B", q, 0);

    // R4: zero width gives one cycle, then a long width
    width = 16'd0;
    d = cyc; riseTrig = 1'b1;
    expectPulse(d + 3, 1, "R4 zero width");
    ticks(6);
    riseTrig = 1'b0;
    ticks(4);
    width = 16'd40;
    d = cyc; riseTrig = 1'b1;
    expectPulse(d + 3, 40, "R4 long width");
    ticks(46);

    // R5: activity during the pulse is ignored
    riseTrig = 1'b0;
    ticks(4);
    width = 16'd12;
    d = cyc; riseTrig = 1'b1;
    expectPulse(d + 3, 12, "R5");
    ticks(4);
    width = 16'd3;
    riseTrig = 1'b0;
    ticks(2);
    riseTrig = 1'b1;
    ticks(2);
    fallTrig = 1'b1;
    ticks(2);
    fallTrig = 1'b0;
    ticks(20);

    // R6: clear cuts the pulse; edges during clear and its release do nothing
    width = 16'd20;
    riseTrig = 1'b0;
    ticks(4);
    d = cyc; riseTrig = 1'b1;
    expectPulse(d + 3, 5, "R6 clear cut");
    ticks(7);
    clrN = 1'b0;
    ticks(2);
    riseTrig = 1'b0;
    ticks(3);
    riseTrig = 1'b1;
    ticks(6);
    check(q == 1'b0, "R6 edge during clear", q, 0);
    clrN = 1'b1;
    ticks(10);
    check(q == 1'b0, "R6 no pulse on release", q, 0);

    // R7: edge in the final cycle dropped, one cycle later accepted
    width = 16'd6;
    fallTrig = 1'b1;
    ticks(4);
    d = cyc; fallTrig = 1'b0;
    expectPulse(d + 3, 6, "R7 first");
    ticks(2);
    fallTrig = 1'b1;
    ticks(4);
    fallTrig = 1'b0;
    ticks(8);
    check(q == 1'b0, "R7 final-cycle edge dropped", q, 0);
    fallTrig = 1'b1;
    ticks(4);
    d = cyc; fallTrig = 1'b0;
    expectPulse(d + 3, 6, "R7 second");
    ticks(2);
    fallTrig = 1'b1;
    ticks(5);
    fallTrig = 1'b0;
    expectPulse(d + 10, 6, "R7 back-to-back");
    ticks(14);

    // R9: short and long trigger levels give the same length
    fallTrig = 1'b1;
    width = 16'd9;
    ticks(4);
    d = cyc; fallTrig = 1'b0;
    expectPulse(d + 3, 9, "R9 short level");
    ticks(1);
    fallTrig = 1'b1;
    ticks(14);
    d = cyc; fallTrig = 1'b0;
    expectPulse(d + 3, 9, "R9 long level");
    ticks(30);
    fallTrig = 1'b1;
    ticks(6);

    check(expQ.size() == 0, "R1/R2/R4 pending expected pulses", expQ.size(), 0);
    check(!inPulse, "R5 no pulse left running", inPulse, 0);
    check(complementErrs == 0, "R8 complement violations", complementErrs, 0);
    done = 1'b1;
    finishRun();
  end

endmodule